// File: doc/BRIEF.md
# Bicolour LED Pattern Controller

This block drives one front status LED and a row of per-drive status LEDs. Each LED has a blue and a red element. A host configures the block over a narrow parallel bus: it sets a 3-bit register address and a 3-bit value, then raises a single strobe. Eight 3-bit registers set the front LED pattern and its brightness, one brightness shared by all drive LEDs, and the pattern of each drive LED.

The block divides the system clock into a half-second tick. A twelve-step phase counter (6 s) is shared by every LED, so all blink patterns stay in step. A free-running 3-bit PWM counter dims each LED to one of eight levels. A drive LED in activity mode shows steady blue while its drive is idle. Each activity pulse blanks it for a fixed stretch, so short bursts stay visible.

The bus front end is a three-state machine. BUS_IDLE waits for the synchronised strobe and moves to BUS_COMMIT, latching address and data on the way. BUS_COMMIT writes one register and always moves to BUS_HOLD. BUS_HOLD stays until the strobe falls and then returns to BUS_IDLE. Each drive LED has a two-state activity machine. ACT_QUIET moves to ACT_BLANK when a synchronised activity sample is seen, loading the stretch counter. ACT_BLANK reloads the counter on every further active sample. It returns to ACT_QUIET when the counter runs out.

Top module: `led_ctrl_top`

## Requirements
- R1: After reset every mode and brightness register is 0, and every blue and red output stays inactive until the host writes a register.
- R2: Each high period of `cfg_strobe` writes exactly one register, however long the strobe is held. Changes on `cfg_addr`/`cfg_data` while the strobe is low write nothing.
- R3: Address 0 selects the front pattern, 1 the front brightness, 2 the shared drive brightness, and 3+i the pattern of drive LED i.
- R4: With brightness b (0..7), a lit colour is active for b of every 8 clock cycles. b=0 keeps the LED dark.
- R5: Front pattern codes 0, 1 and 2 give off, steady blue and steady red.
- R6: A tick occurs every `TICK_DIV` cycles (0.5 s). Code 3 gives blue 1 s on, 1 s off. Code 4 gives red 1 s on, 1 s off.
- R7: Code 5 alternates blue 2.5 s with red 0.5 s. Code 6 alternates blue 1 s with red 1 s. Front code 7 gives blue 0.5 s on, then 2.5 s off.
- R8: Drive LED codes 0 and 2 to 6 behave as the front codes; drive code 7 is steady blue.
- R9: Drive code 1 is steady blue while `drv_act_n` is high. A low sample on `drv_act_n` blanks the LED until `STRETCH` cycles after the last low sample.
- R10: On no LED are the blue and red outputs active in the same cycle.
- R11: Activity pulses have no effect on a drive LED whose code is not 1.
- R12: The front brightness affects only the front LED. The shared drive brightness applies to every drive LED and not to the front LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_strobe | input | 1 | Write strobe, asynchronous, one write per high period |
| cfg_addr | input | 3 | Register address, stable while strobe high |
| cfg_data | input | 3 | Register value, stable while strobe high |
| drv_act_n | input | N_DRIVE | Active-low drive activity signals |
| front_blue | output | 1 | Front LED blue element |
| front_red | output | 1 | Front LED red element |
| drv_blue | output | N_DRIVE | Drive LED blue elements |
| drv_red | output | N_DRIVE | Drive LED red elements |

## Verification
The hardest situation to reach from the ports is the activity blank. It lasts a fixed number of cycles, starts after synchroniser latency and overlaps a PWM waveform, so its exact edges are not visible. The bench measures lit cycles over a window that is a multiple of the PWM period and fully contains the blank. With a stretch that is a multiple of 8, a single-cycle pulse and a nine-cycle pulse remove an exact, predictable number of lit cycles. Blink patterns are checked the same way, over one full 6 s phase period, so the count does not depend on where the window starts.

// File: rtl/led_pkg.sv
package led_pkg;
    localparam int CODE_W  = 3;
    localparam int PHASES  = 12;
    localparam int PHASE_W = 4;
    localparam int PWM_W   = 3;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [CODE_W-1:0] {
        PAT_OFF       = 3'd0,
        PAT_BLUE      = 3'd1,
        PAT_RED       = 3'd2,
        PAT_BLUE_SLOW = 3'd3,
        PAT_RED_SLOW  = 3'd4,
        PAT_BLUE_LONG = 3'd5,
        PAT_ALTERNATE = 3'd6,
        PAT_BLUE_LAST = 3'd7
    } pat_e;

    typedef struct packed {
        logic blue;
        logic red;
    } hue_t;

    function automatic hue_t pattern_hue(input code_t mode,
                                         input logic [PHASE_W-1:0] phase,
                                         input logic is_drive);
        hue_t h;
        logic [PHASE_W-1:0] p6;
        p6 = (phase >= PHASE_W'(6)) ? phase - PHASE_W'(6) : phase;
        h  = '0;
        unique case (pat_e'(mode))
            PAT_OFF:       h = '0;
            PAT_BLUE:      h.blue = 1'b1;
            PAT_RED:       h.red  = 1'b1;
            PAT_BLUE_SLOW: h.blue = ~phase[1];
            PAT_RED_SLOW:  h.red  = ~phase[1];
            PAT_BLUE_LONG: begin
                h.blue = (p6 != PHASE_W'(5));
                h.red  = (p6 == PHASE_W'(5));
            end
            PAT_ALTERNATE: begin
                h.blue = ~phase[1];
                h.red  = phase[1];
            end
            PAT_BLUE_LAST: h.blue = is_drive ? 1'b1 : (p6 == '0);
            default:       h = '0;
        endcase
        return h;
    endfunction
endpackage

// File: rtl/led_timebase.sv
module led_timebase
    import led_pkg::*;
#(
    parameter int TICK_DIV = 25_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               tick,
    output logic [PHASE_W-1:0] phase,
    output logic [PWM_W-1:0]   pwm
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == DIV_W'(TICK_DIV - 1)) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == PHASE_W'(PHASES - 1)) ? '0 : phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm <= '0;
        else        pwm <= pwm + 1'b1;
    end

    p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PHASE_W'(PHASES));
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/led_cfg_bus.sv
module led_cfg_bus
    import led_pkg::*;
#(
    parameter int N_DRIVE = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic [2:0]               addr,
    input  code_t                    data,
    output code_t                    front_mode,
    output code_t                    front_bri,
    output code_t                    drv_bri,
    output logic [N_DRIVE-1:0][CODE_W-1:0] drv_mode
);
    localparam int ADDR_FRONT_MODE = 0;
    localparam int ADDR_FRONT_BRI  = 1;
    localparam int ADDR_DRV_BRI    = 2;
    localparam int ADDR_DRV_BASE   = 3;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_COMMIT,
        BUS_HOLD
    } bus_st_e;

    bus_st_e    st_q, st_d;
    logic [1:0] sync_q;
    logic       strb_s;
    logic [2:0] addr_q;
    code_t      data_q;
    logic       wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], strobe};
    end
    assign strb_s = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE:   if (strb_s) st_d = BUS_COMMIT;
            BUS_COMMIT: st_d = BUS_HOLD;
            BUS_HOLD:   if (!strb_s) st_d = BUS_IDLE;
            default:    st_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (st_q == BUS_IDLE && strb_s) begin
            addr_q <= addr;
            data_q <= data;
        end
    end

    assign wr_en = (st_q == BUS_COMMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_mode <= '0;
            front_bri  <= '0;
            drv_bri    <= '0;
        end else if (wr_en) begin
            if (addr_q == 3'(ADDR_FRONT_MODE)) front_mode <= data_q;
            if (addr_q == 3'(ADDR_FRONT_BRI))  front_bri  <= data_q;
            if (addr_q == 3'(ADDR_DRV_BRI))    drv_bri    <= data_q;
        end
    end

    for (genvar i = 0; i < N_DRIVE; i++) begin : g_drv_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                drv_mode[i] <= '0;
            end else if (wr_en && addr_q == 3'(ADDR_DRV_BASE + i)) begin
                drv_mode[i] <= data_q;
            end
        end
    end

    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    p_no_rewrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BUS_HOLD && strb_s) |=> !wr_en);
    p_regs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(front_mode) && $stable(front_bri) && $stable(drv_bri)
                    && $stable(drv_mode)));
endmodule

// File: rtl/led_pattern.sv
module led_pattern
    import led_pkg::*;
#(
    parameter bit IS_DRIVE = 1'b0,
    parameter int STRETCH  = 2_500_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  code_t              mode,
    input  code_t              bri,
    input  logic [PHASE_W-1:0] phase,
    input  logic [PWM_W-1:0]   pwm,
    input  logic               act_n,
    output logic               blue,
    output logic               red
);
    localparam int CNT_W = $clog2(STRETCH + 1);

    typedef enum logic {
        ACT_QUIET,
        ACT_BLANK
    } act_st_e;

    act_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       act_sync_q;
    logic             act_s;
    hue_t             hue;
    logic             follow, lit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_sync_q <= '0;
        else        act_sync_q <= {act_sync_q[0], ~act_n};
    end
    assign act_s = act_sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ACT_QUIET;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ACT_QUIET: begin
                if (act_s) begin
                    st_d  = ACT_BLANK;
                    cnt_d = CNT_W'(STRETCH);
                end
            end
            ACT_BLANK: begin
                if (act_s) begin
                    cnt_d = CNT_W'(STRETCH);
                end else if (cnt_q <= CNT_W'(1)) begin
                    st_d  = ACT_QUIET;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ACT_QUIET;
        endcase
    end

    assign hue    = pattern_hue(mode, phase, IS_DRIVE);
    assign follow = IS_DRIVE && (mode == code_t'(PAT_BLUE));
    assign lit    = (pwm < bri) && !(follow && st_q == ACT_BLANK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blue <= 1'b0;
            red  <= 1'b0;
        end else begin
            blue <= lit && hue.blue;
            red  <= lit && hue.red;
        end
    end

    p_colour_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(blue && red));
    p_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bri == '0) |=> (!blue && !red));
    p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (follow && st_q == ACT_BLANK) |=> !blue);
    p_stretch_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_s |=> (st_q == ACT_BLANK));
endmodule

// File: rtl/led_ctrl_top.sv
module led_ctrl_top
    import led_pkg::*;
#(
    parameter int TICK_DIV = 25_000_000,
    parameter int STRETCH  = 2_500_000,
    parameter int N_DRIVE  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_strobe,
    input  logic [2:0]         cfg_addr,
    input  logic [2:0]         cfg_data,
    input  logic [N_DRIVE-1:0] drv_act_n,
    output logic               front_blue,
    output logic               front_red,
    output logic [N_DRIVE-1:0] drv_blue,
    output logic [N_DRIVE-1:0] drv_red
);
    logic                          tick;
    logic [PHASE_W-1:0]            phase;
    logic [PWM_W-1:0]              pwm;
    code_t                         front_mode, front_bri, drv_bri;
    logic [N_DRIVE-1:0][CODE_W-1:0] drv_mode;

    led_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .phase (phase),
        .pwm   (pwm)
    );

    led_cfg_bus #(.N_DRIVE(N_DRIVE)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (cfg_strobe),
        .addr       (cfg_addr),
        .data       (cfg_data),
        .front_mode (front_mode),
        .front_bri  (front_bri),
        .drv_bri    (drv_bri),
        .drv_mode   (drv_mode)
    );

    led_pattern #(.IS_DRIVE(1'b0), .STRETCH(STRETCH)) u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (front_mode),
        .bri   (front_bri),
        .phase (phase),
        .pwm   (pwm),
        .act_n (1'b1),
        .blue  (front_blue),
        .red   (front_red)
    );

    for (genvar i = 0; i < N_DRIVE; i++) begin : g_drive
        led_pattern #(.IS_DRIVE(1'b1), .STRETCH(STRETCH)) u_drive (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (drv_mode[i]),
            .bri   (drv_bri),
            .phase (phase),
            .pwm   (pwm),
            .act_n (drv_act_n[i]),
            .blue  (drv_blue[i]),
            .red   (drv_red[i])
        );
    end

    p_tick_advances_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase != $past(phase)));
    p_reset_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (front_mode == '0) |=> !front_blue && !front_red);
endmodule

// File: tb/test_led_ctrl_top.sv
module test_led_ctrl_top;
    localparam int TICK_DIV = 16;
    localparam int STRETCH  = 40;
    localparam int N_DRIVE  = 5;
    localparam int PERIOD   = 12 * TICK_DIV;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_strobe = 1'b0;
    logic [2:0]         cfg_addr = '0;
    logic [2:0]         cfg_data = '0;
    logic [N_DRIVE-1:0] drv_act_n = '1;
    logic               front_blue, front_red;
    logic [N_DRIVE-1:0] drv_blue, drv_red;

    int total = 0;
    int bad   = 0;
    int overlap = 0;
    bit busy = 0;
    bit finished = 0;

    typedef struct {
        string tag;
        int    led;
        int    win;
        int    eb;
        int    er;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    led_ctrl_top #(.TICK_DIV(TICK_DIV), .STRETCH(STRETCH), .N_DRIVE(N_DRIVE)) i_led_ctrl_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_strobe (cfg_strobe),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .drv_act_n  (drv_act_n),
        .front_blue (front_blue),
        .front_red  (front_red),
        .drv_blue   (drv_blue),
        .drv_red    (drv_red)
    );

    function automatic logic get_b(int led);
        return (led == 0) ? front_blue : drv_blue[led-1];
    endfunction
    function automatic logic get_r(int led);
        return (led == 0) ? front_red : drv_red[led-1];
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (front_blue && front_red) overlap++;
            for (int i = 0; i < N_DRIVE; i++)
                if (drv_blue[i] && drv_red[i]) overlap++;
        end
    end

    // monitor: pops expected items and measures lit cycles
    initial begin
        item_t it;
        int nb, nr;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                busy = 1;
                it = q.pop_front();
                nb = 0;
                nr = 0;
                for (int k = 0; k < it.win; k++) begin
                    @(negedge clk);
                    if (get_b(it.led)) nb++;
                    if (get_r(it.led)) nr++;
                end
                total++;
                if (nb != it.eb || nr != it.er) begin
                    bad++;
                    $display("FAIL %s led=%0d blue=%0d red=%0d expected blue=%0d red=%0d",
                             it.tag, it.led, nb, nr, it.eb, it.er);
                end
                busy = 0;
            end
        end
    end

    task automatic push(string tag, int led, int win, int eb, int er);
        item_t it;
        it.tag = tag; it.led = led; it.win = win; it.eb = eb; it.er = er;
        q.push_back(it);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0 || busy) @(negedge clk);
    endtask

    task automatic bus_write(int a, int d, int hold);
        @(negedge clk);
        cfg_addr = 3'(a);
        cfg_data = 3'(d);
        @(negedge clk);
        cfg_strobe = 1'b1;
        repeat (hold) @(negedge clk);
        cfg_strobe = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // expected lit cycles over one full phase period: halves * TICK_DIV * b / 8
    function automatic int lit(int halves, int b);
        return halves * TICK_DIV * b / 8;
    endfunction

    task automatic check_period(string tag, int led, int hb, int hr, int b);
        push(tag, led, PERIOD, lit(hb, b), lit(hr, b));
        wait_idle();
    endtask

    task automatic pulse_check(string tag, int led, int plen, int exp_b);
        push(tag, led, 200, exp_b, 0);
        repeat (40) @(negedge clk);
        drv_act_n[led-1] = 1'b0;
        repeat (plen) @(negedge clk);
        drv_act_n[led-1] = 1'b1;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: dark after reset
        check_period("R1 front dark after reset", 0, 0, 0, 8);
        check_period("R1 drive0 dark after reset", 1, 0, 0, 8);
        check_period("R1 drive4 dark after reset", 5, 0, 0, 8);

        // R3 R5 R4: front steady blue at brightness 3
        bus_write(0, 1, 3);
        bus_write(1, 3, 3);
        check_period("R3 R5 front steady blue b3", 0, 12, 0, 3);
        bus_write(1, 7, 3);
        check_period("R4 front b7 duty 7/8", 0, 12, 0, 7);
        bus_write(1, 0, 3);
        check_period("R4 front b0 dark", 0, 0, 0, 7);
        bus_write(1, 5, 3);
        bus_write(0, 2, 3);
        check_period("R5 front steady red b5", 0, 0, 12, 5);
        bus_write(0, 0, 3);
        check_period("R5 front off", 0, 0, 0, 5);

        // R6: 1 s on / 1 s off
        bus_write(1, 7, 3);
        bus_write(0, 3, 3);
        check_period("R6 front blue slow blink", 0, 6, 0, 7);
        bus_write(0, 4, 3);
        check_period("R6 front red slow blink", 0, 0, 6, 7);

        // R7: alternations and short flash
        bus_write(0, 5, 3);
        check_period("R7 front blue 2.5 red 0.5", 0, 10, 2, 7);
        bus_write(0, 6, 3);
        check_period("R7 front blue 1 red 1", 0, 6, 6, 7);
        bus_write(0, 7, 3);
        check_period("R7 front short blue flash", 0, 2, 0, 7);

        // R8: drive codes
        bus_write(2, 4, 3);
        bus_write(5, 7, 3);
        check_period("R8 drive2 code7 steady blue", 3, 12, 0, 4);
        bus_write(3, 3, 3);
        check_period("R8 drive0 code3 slow blink", 1, 6, 0, 4);
        bus_write(7, 5, 3);
        check_period("R8 drive4 code5 alternation", 5, 10, 2, 4);

        // R12: brightness independence
        check_period("R12 front keeps own brightness", 0, 2, 0, 7);
        bus_write(1, 2, 3);
        check_period("R12 drive2 unaffected by front brightness", 3, 12, 0, 4);
        check_period("R12 front b2", 0, 2, 0, 2);

        // R2: long strobe writes once; address change without strobe ignored
        bus_write(4, 2, 30);
        check_period("R2 drive1 long strobe red", 2, 0, 12, 4);
        @(negedge clk);
        cfg_addr = 3'd4;
        cfg_data = 3'd0;
        repeat (10) @(negedge clk);
        check_period("R2 no write without strobe", 2, 0, 12, 4);

        // R9: activity follow
        bus_write(2, 7, 3);
        bus_write(6, 1, 3);
        check_period("R9 drive3 idle steady blue", 4, 12, 0, 7);
        pulse_check("R9 single cycle pulse blank", 4, 1, 175 - 35);
        pulse_check("R9 nine cycle pulse blank", 4, 9, 175 - 42);

        // R11: activity ignored in other codes
        bus_write(6, 3, 3);
        push("R11 activity ignored code3", 4, PERIOD, lit(6, 7), 0);
        repeat (50) @(negedge clk);
        drv_act_n[3] = 1'b0;
        repeat (5) @(negedge clk);
        drv_act_n[3] = 1'b1;
        wait_idle();

        // R10: colours exclusive over the whole run
        total++;
        if (overlap != 0) begin
            bad++;
            $display("FAIL R10 colour overlap cycles=%0d expected=0", overlap);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule